// File: doc/BRIEF.md
# Keyed Flash Command Sequencer

This block sits between a register bus and an embedded flash array and turns software commands into array operations. Software first loads a doubleword target address and two 32-bit halves of a 64-bit data word into keyhole registers. For a destructive command it then writes an unlock value to a key register. Finally it writes a 5-bit command code. The sequencer drives the array through one-cycle start strobes and waits for a one-cycle completion pulse from the array. The outcome is reported in a status word as a busy bit, a 2-bit completion code and a verify-failure flag.

Three operations are supported. A single 64-bit word write needs no key. A mass erase of bank 0 or bank 1 needs the key. After the array reports that the erase is done, the block reads back every word of the erased bank in ascending order and flags any word that is not all ones. An abort also needs the key. It is the only command honoured while another command is running, and it ends that command with an error code. A page-number register is held for software but drives no operation.

The state machine has four states:
- `ST_IDLE`: waiting for a command.
- `ST_PROG`: waiting for a word write to finish.
- `ST_ERASE`: waiting for a mass erase to finish.
- `ST_VERIFY`: reading back the erased bank one word at a time.

The transitions are:
- IDLE to PROG on an accepted write.
- IDLE to ERASE on a keyed erase.
- PROG to IDLE on array done.
- ERASE to VERIFY on array done.
- VERIFY to VERIFY on array done for any word but the last.
- VERIFY to IDLE on array done for the last word.
- PROG, ERASE or VERIFY to IDLE on a keyed abort. A keyed abort takes priority over array done in the same cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset the status word reads 0, and the address, lower data, upper data, page and key registers all read 0.
- R2: Bus word offsets are: 0 command (write-only), 1 key (reads 0), 2 address, 3 lower data, 4 upper data, 5 page, 6 status (read-only). The address register keeps write bits [18:3] and reads 0 in bits [2:0] and [31:19]. The page register keeps bits [18:11] and reads 0 elsewhere.
- R3: Command code 5'b00100 issues one program strobe. Its array address is the address register's bits [18:3] (low `IDX_W` bits). Its data has the lower data register in bits [31:0] and the upper data register in bits [63:32]. On array done the completion code becomes 2'b01. The status word has completion code in bits [1:0], busy in bit 2 and verify error in bit 3.
- R4: Codes 5'b00101 and 5'b00110 erase bank 0 and bank 1, only when the key 32'hF123F456 was the last value written to the key register. An unkeyed erase issues no strobe and sets completion code 2'b11.
- R5: After erase done, the block issues one read per word of the erased bank, at addresses bank*BANK_WORDS up to bank*BANK_WORDS+BANK_WORDS-1 in ascending order. If every word is all ones, it ends with code 2'b01 and verify flag 0.
- R6: If any read-back word differs from 64'hFFFF_FFFF_FFFF_FFFF, the remaining words are still read, and the block ends with the verify flag at 1 and code 2'b11.
- R7: A keyed abort (5'b01000) during a running command issues one abort strobe, clears busy and sets code 2'b11 in the same cycle. After that, commands are accepted again.
- R8: While busy, any non-abort command and any unkeyed abort are ignored. The running command and its status are left unchanged.
- R9: Any command write clears the key, whether the command is accepted, rejected or ignored. A key-register write of any other value also disarms it.
- R10: When idle, a reserved code or an abort sets code 2'b11 and issues no strobe.
- R11: Each array strobe lasts one cycle, and at most one strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write enable |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational on bus_addr |
| fa_prog | output | 1 | Array program start strobe |
| fa_erase | output | 1 | Array bank erase start strobe |
| fa_read | output | 1 | Array read start strobe |
| fa_abort | output | 1 | Array stop strobe |
| fa_bank | output | 1 | Bank selected for erase |
| fa_addr | output | IDX_W | Array doubleword address |
| fa_wdata | output | 64 | Array program data |
| fa_rdata | input | 64 | Array read data, valid with fa_done |
| fa_done | input | 1 | Array operation complete pulse |

## Verification
A keyed abort and the array's done pulse can land in the same cycle. In that case abort must win: no success code, an abort strobe, and code 2'b11. The bench waits for the done pulse of a running word write, with the key already written during the busy window. It then drives the abort command on that very cycle. The result is judged from the scoreboard, which expects an abort strobe after the program strobe, and from the status word, which must read 0x3.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    localparam logic [4:0]  CMD_WRITE  = 5'b00100;
    localparam logic [4:0]  CMD_ERASE0 = 5'b00101;
    localparam logic [4:0]  CMD_ERASE1 = 5'b00110;
    localparam logic [4:0]  CMD_ABORT  = 5'b01000;

    localparam logic [31:0] UNLOCK_KEY = 32'hF123F456;

    localparam logic [2:0]  OFF_CMD  = 3'd0;
    localparam logic [2:0]  OFF_KEY  = 3'd1;
    localparam logic [2:0]  OFF_ADDR = 3'd2;
    localparam logic [2:0]  OFF_DLO  = 3'd3;
    localparam logic [2:0]  OFF_DHI  = 3'd4;
    localparam logic [2:0]  OFF_PAGE = 3'd5;
    localparam logic [2:0]  OFF_STAT = 3'd6;

    localparam logic [1:0]  CPL_IDLE = 2'b00;
    localparam logic [1:0]  CPL_OK   = 2'b01;
    localparam logic [1:0]  CPL_ERR  = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_VERIFY
    } seq_state_t;

endpackage

// File: rtl/flash_seq_regs.sv
`timescale 1ns/1ps
module flash_seq_regs
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [31:0] stat_word,
    output logic [31:0] bus_rdata,
    output logic        cmd_wr,
    output logic [4:0]  cmd_code,
    output logic        key_ok,
    output logic [15:0] dw_addr,
    output logic [63:0] wr_data
);

    logic [31:0] lo_q;
    logic [31:0] hi_q;
    logic [7:0]  page_q;

    // Keyhole registers and the one-shot unlock flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            page_q  <= '0;
            dw_addr <= '0;
            key_ok  <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_KEY:  key_ok  <= (bus_wdata == UNLOCK_KEY);
                OFF_CMD:  key_ok  <= 1'b0;
                OFF_ADDR: dw_addr <= bus_wdata[18:3];
                OFF_DLO:  lo_q    <= bus_wdata;
                OFF_DHI:  hi_q    <= bus_wdata;
                OFF_PAGE: page_q  <= bus_wdata[18:11];
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_ADDR: bus_rdata = {13'b0, dw_addr, 3'b0};
            OFF_DLO:  bus_rdata = lo_q;
            OFF_DHI:  bus_rdata = hi_q;
            OFF_PAGE: bus_rdata = {13'b0, page_q, 11'b0};
            OFF_STAT: bus_rdata = stat_word;
            default:  bus_rdata = '0;
        endcase
    end

    assign cmd_wr   = bus_wr && (bus_addr == OFF_CMD);
    assign cmd_code = bus_wdata[4:0];
    assign wr_data  = {hi_q, lo_q};

endmodule

// File: rtl/flash_seq_fsm.sv
`timescale 1ns/1ps
module flash_seq_fsm
    import flash_seq_pkg::*;
#(
    parameter  int BANK_WORDS = 32768,
    localparam int VC_W       = $clog2(BANK_WORDS),
    localparam int IDX_W      = VC_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [4:0]       cmd_code,
    input  logic             key_ok,
    input  logic [15:0]      dw_addr,
    input  logic [63:0]      wr_data,
    input  logic             fa_done,
    input  logic [63:0]      fa_rdata,
    output logic             fa_prog,
    output logic             fa_erase,
    output logic             fa_read,
    output logic             fa_abort,
    output logic             fa_bank,
    output logic [IDX_W-1:0] fa_addr,
    output logic [63:0]      fa_wdata,
    output logic             busy,
    output logic [1:0]       cpl,
    output logic             verr
);

    localparam logic [VC_W-1:0] LAST_IDX = VC_W'(BANK_WORDS - 1);

    seq_state_t       st, nxt;
    logic [VC_W-1:0]  vidx;
    logic [IDX_W-1:0] op_addr;
    logic             kill, is_erase, last_word, bad_word;

    assign kill      = cmd_wr && (cmd_code == CMD_ABORT) && key_ok;
    assign is_erase  = (cmd_code == CMD_ERASE0) || (cmd_code == CMD_ERASE1);
    assign last_word = (vidx == LAST_IDX);
    assign bad_word  = (fa_rdata != {64{1'b1}});

    // Next-state decode; a keyed abort outranks array completion
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (cmd_wr && cmd_code == CMD_WRITE)        nxt = ST_PROG;
                else if (cmd_wr && is_erase && key_ok)      nxt = ST_ERASE;
            end
            ST_PROG: begin
                if (kill || fa_done)                        nxt = ST_IDLE;
            end
            ST_ERASE: begin
                if (kill)                                   nxt = ST_IDLE;
                else if (fa_done)                           nxt = ST_VERIFY;
            end
            ST_VERIFY: begin
                if (kill || (fa_done && last_word))         nxt = ST_IDLE;
            end
            default:                                        nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Registered outputs: strobes, operands and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_prog  <= 1'b0;
            fa_erase <= 1'b0;
            fa_read  <= 1'b0;
            fa_abort <= 1'b0;
            fa_bank  <= 1'b0;
            fa_wdata <= '0;
            op_addr  <= '0;
            vidx     <= '0;
            busy     <= 1'b0;
            cpl      <= CPL_IDLE;
            verr     <= 1'b0;
        end else begin
            fa_prog  <= 1'b0;
            fa_erase <= 1'b0;
            fa_read  <= 1'b0;
            fa_abort <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (cmd_wr) begin
                        verr <= 1'b0;
                        if (cmd_code == CMD_WRITE) begin
                            fa_prog  <= 1'b1;
                            op_addr  <= dw_addr[IDX_W-1:0];
                            fa_wdata <= wr_data;
                            busy     <= 1'b1;
                            cpl      <= CPL_IDLE;
                        end else if (is_erase && key_ok) begin
                            fa_erase <= 1'b1;
                            fa_bank  <= (cmd_code == CMD_ERASE1);
                            vidx     <= '0;
                            busy     <= 1'b1;
                            cpl      <= CPL_IDLE;
                        end else begin
                            cpl      <= CPL_ERR;
                        end
                    end
                end
                ST_PROG: begin
                    if (kill) begin
                        fa_abort <= 1'b1;
                        busy     <= 1'b0;
                        cpl      <= CPL_ERR;
                    end else if (fa_done) begin
                        busy     <= 1'b0;
                        cpl      <= CPL_OK;
                    end
                end
                ST_ERASE: begin
                    if (kill) begin
                        fa_abort <= 1'b1;
                        busy     <= 1'b0;
                        cpl      <= CPL_ERR;
                    end else if (fa_done) begin
                        fa_read  <= 1'b1;
                        vidx     <= '0;
                    end
                end
                ST_VERIFY: begin
                    if (kill) begin
                        fa_abort <= 1'b1;
                        busy     <= 1'b0;
                        cpl      <= CPL_ERR;
                    end else if (fa_done) begin
                        if (bad_word) verr <= 1'b1;
                        if (last_word) begin
                            busy <= 1'b0;
                            cpl  <= (verr || bad_word) ? CPL_ERR : CPL_OK;
                        end else begin
                            vidx    <= vidx + VC_W'(1);
                            fa_read <= 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign fa_addr = (st == ST_VERIFY) ? {fa_bank, vidx} : op_addr;

endmodule

// File: rtl/flash_cmd_seq.sv
`timescale 1ns/1ps
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter  int BANK_WORDS = 32768,
    localparam int IDX_W      = $clog2(BANK_WORDS) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             fa_prog,
    output logic             fa_erase,
    output logic             fa_read,
    output logic             fa_abort,
    output logic             fa_bank,
    output logic [IDX_W-1:0] fa_addr,
    output logic [63:0]      fa_wdata,
    input  logic [63:0]      fa_rdata,
    input  logic             fa_done
);

    logic        cmd_wr_w;
    logic [4:0]  cmd_code_w;
    logic        key_ok_w;
    logic [15:0] dw_addr_w;
    logic [63:0] wr_data_w;
    logic        busy_w;
    logic [1:0]  cpl_w;
    logic        verr_w;
    logic [31:0] stat_w;

    assign stat_w = {28'b0, verr_w, busy_w, cpl_w};

    flash_seq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .stat_word (stat_w),
        .bus_rdata (bus_rdata),
        .cmd_wr    (cmd_wr_w),
        .cmd_code  (cmd_code_w),
        .key_ok    (key_ok_w),
        .dw_addr   (dw_addr_w),
        .wr_data   (wr_data_w)
    );

    flash_seq_fsm #(.BANK_WORDS(BANK_WORDS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr_w),
        .cmd_code (cmd_code_w),
        .key_ok   (key_ok_w),
        .dw_addr  (dw_addr_w),
        .wr_data  (wr_data_w),
        .fa_done  (fa_done),
        .fa_rdata (fa_rdata),
        .fa_prog  (fa_prog),
        .fa_erase (fa_erase),
        .fa_read  (fa_read),
        .fa_abort (fa_abort),
        .fa_bank  (fa_bank),
        .fa_addr  (fa_addr),
        .fa_wdata (fa_wdata),
        .busy     (busy_w),
        .cpl      (cpl_w),
        .verr     (verr_w)
    );

endmodule

// File: rtl/flash_seq_chk.sv
`timescale 1ns/1ps
module flash_seq_chk
    import flash_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_rdata,
    input logic        fa_prog,
    input logic        fa_erase,
    input logic        fa_read,
    input logic        fa_abort,
    input logic        busy,
    input logic [1:0]  cpl,
    input logic        verr,
    input logic        key_ok
);

    // R11: never two array strobes together
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fa_prog, fa_erase, fa_read, fa_abort}));

    // R11: start strobes last a single cycle
    a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fa_prog || fa_erase) |=> !(fa_prog || fa_erase));

    // R3: array work is only started while busy
    a_r3_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fa_prog || fa_erase || fa_read) |-> busy);

    // R7: abort strobe comes with idle and error code
    a_r7_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
        fa_abort |-> (!busy && cpl == CPL_ERR));

    // R6: a finished command with a verify failure reports error
    a_r6_verr_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && verr) |-> (cpl == CPL_ERR));

    // R9: key does not survive a command write
    a_r9_key_spent: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_CMD) |=> !key_ok);

    // R2: reserved address-register bits read zero
    a_r2_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFF_ADDR) |-> (bus_rdata[2:0] == 3'b0 && bus_rdata[31:19] == 13'b0));

    // R8: completion code stays idle while a command runs
    a_r8_busy_code: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cpl == CPL_IDLE));

endmodule

bind flash_cmd_seq flash_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .fa_prog   (fa_prog),
    .fa_erase  (fa_erase),
    .fa_read   (fa_read),
    .fa_abort  (fa_abort),
    .busy      (busy_w),
    .cpl       (cpl_w),
    .verr      (verr_w),
    .key_ok    (key_ok_w)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
    import flash_seq_pkg::*;

    localparam int BW        = 8;
    localparam int IW        = 4;
    localparam int NW        = 16;
    localparam int PROG_LAT  = 12;
    localparam int ERASE_LAT = 10;

    localparam logic [1:0] K_PROG  = 2'd0;
    localparam logic [1:0] K_ERASE = 2'd1;
    localparam logic [1:0] K_READ  = 2'd2;
    localparam logic [1:0] K_ABORT = 2'd3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic          bus_wr;
    logic [2:0]    bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          fa_prog, fa_erase, fa_read, fa_abort, fa_bank;
    logic [IW-1:0] fa_addr;
    logic [63:0]   fa_wdata;
    logic [63:0]   fa_rdata;
    logic          fa_done;

    flash_cmd_seq #(.BANK_WORDS(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fa_prog(fa_prog),
        .fa_erase(fa_erase), .fa_read(fa_read), .fa_abort(fa_abort),
        .fa_bank(fa_bank), .fa_addr(fa_addr), .fa_wdata(fa_wdata),
        .fa_rdata(fa_rdata), .fa_done(fa_done)
    );

    // ---------------- behavioural array ----------------
    logic [63:0]   mem [NW];
    int            cnt;
    logic [1:0]    pk;
    logic [IW-1:0] pa;
    logic [63:0]   pd;
    logic          pb;
    logic          stuck_en;
    int            stuck_idx;

    always @(posedge clk) begin
        fa_done <= 1'b0;
        if (!rst_n) begin
            cnt      <= 0;
            pk       <= K_PROG;
            pa       <= '0;
            pd       <= '0;
            pb       <= 1'b0;
            fa_rdata <= '0;
            for (int i = 0; i < NW; i++) mem[i] <= '0;
        end else if (fa_abort) begin
            cnt <= 0;
        end else if (fa_prog) begin
            cnt <= PROG_LAT; pk <= K_PROG; pa <= fa_addr; pd <= fa_wdata;
        end else if (fa_erase) begin
            cnt <= ERASE_LAT; pk <= K_ERASE; pb <= fa_bank;
        end else if (fa_read) begin
            cnt <= 1; pk <= K_READ; pa <= fa_addr;
        end else if (cnt == 1) begin
            cnt     <= 0;
            fa_done <= 1'b1;
            case (pk)
                K_PROG:  mem[pa] <= pd;
                K_ERASE: for (int i = 0; i < BW; i++)
                             if (!(stuck_en && (int'(pb) * BW + i) == stuck_idx))
                                 mem[int'(pb) * BW + i] <= '1;
                K_READ:  fa_rdata <= mem[pa];
                default: ;
            endcase
        end else if (cnt > 1) begin
            cnt <= cnt - 1;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] addr;
        logic [63:0] data;
    } ev_t;

    ev_t exp_q[$];
    int  vectors = 0;
    int  errors  = 0;
    bit  closed  = 0;

    task automatic tally(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push(logic [1:0] k, logic [15:0] a, logic [63:0] d);
        ev_t e;
        e.kind = k; e.addr = a; e.data = d;
        exp_q.push_back(e);
    endtask

    // Monitor: every strobe cycle pops one expected item (R11: a long strobe pops twice)
    always @(negedge clk) begin : monitor
        ev_t        e;
        logic [1:0] k;
        if (rst_n && (fa_prog || fa_erase || fa_read || fa_abort)) begin
            k = fa_prog ? K_PROG : fa_erase ? K_ERASE : fa_read ? K_READ : K_ABORT;
            if (exp_q.size() == 0) begin
                tally(1'b0, "R11", "unexpected strobe kind", 64'(k), 64'hx);
            end else begin
                e = exp_q.pop_front();
                tally(k == e.kind, "R11", "strobe kind", 64'(k), 64'(e.kind));
                if (e.kind == K_PROG && k == K_PROG) begin
                    tally(64'(fa_addr) == 64'(e.addr), "R3", "program address", 64'(fa_addr), 64'(e.addr));
                    tally(fa_wdata == e.data, "R3", "program data", fa_wdata, e.data);
                end
                if (e.kind == K_READ && k == K_READ)
                    tally(64'(fa_addr) == 64'(e.addr), "R5", "verify address", 64'(fa_addr), 64'(e.addr));
                if (e.kind == K_ERASE && k == K_ERASE)
                    tally(64'(fa_bank) == 64'(e.addr), "R4", "erase bank", 64'(fa_bank), 64'(e.addr));
                if (e.kind == K_ABORT && k == K_ABORT)
                    tally(1'b1, "R7", "abort strobe", 64'(k), 64'(e.kind));
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic expect_reg(logic [2:0] a, logic [31:0] expv, string req, string what);
        logic [31:0] d;
        bus_read(a, d);
        tally(d == expv, req, what, 64'(d), 64'(expv));
    endtask

    task automatic wait_idle(string req);
        logic [31:0] d;
        int n;
        n = 0;
        do begin
            bus_read(OFF_STAT, d);
            n++;
        end while (d[2] && n < 500);
        if (d[2]) tally(1'b0, req, "busy never cleared", 64'(d), 64'h0);
    endtask

    task automatic cmd(logic [4:0] c);
        bus_write(OFF_CMD, {27'b0, c});
    endtask

    task automatic start_write(int idx, logic [31:0] lo, logic [31:0] hi);
        bus_write(OFF_ADDR, 32'(idx) << 3);
        bus_write(OFF_DLO, lo);
        bus_write(OFF_DHI, hi);
        push(K_PROG, 16'(idx), {hi, lo});
        cmd(CMD_WRITE);
    endtask

    task automatic keyed_erase(logic b);
        bus_write(OFF_KEY, UNLOCK_KEY);
        push(K_ERASE, 16'(b), '0);
        for (int i = 0; i < BW; i++) push(K_READ, 16'(int'(b) * BW + i), '0);
        cmd(b ? CMD_ERASE1 : CMD_ERASE0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!closed) begin
            closed = 1;
            errors++;
            vectors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        stuck_en = 1'b0; stuck_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(OFF_STAT, 32'h0, "R1", "status after reset");
        expect_reg(OFF_ADDR, 32'h0, "R1", "address after reset");
        expect_reg(OFF_DLO,  32'h0, "R1", "lower data after reset");
        expect_reg(OFF_DHI,  32'h0, "R1", "upper data after reset");
        expect_reg(OFF_PAGE, 32'h0, "R1", "page after reset");
        expect_reg(OFF_KEY,  32'h0, "R1", "key after reset");

        // R2 register field masking
        bus_write(OFF_ADDR, 32'hFFFF_FFFF);
        expect_reg(OFF_ADDR, 32'h0007_FFF8, "R2", "address masking");
        bus_write(OFF_PAGE, 32'hFFFF_FFFF);
        expect_reg(OFF_PAGE, 32'h0007_F800, "R2", "page masking");
        bus_write(OFF_KEY, UNLOCK_KEY);
        expect_reg(OFF_KEY, 32'h0, "R2", "key reads zero");
        cmd(5'b11111); // spend key, error code

        // R3 word writes, two patterns
        start_write(5, 32'h1122_3344, 32'hAABB_CCDD);
        expect_reg(OFF_STAT, 32'h4, "R3", "busy during write");
        wait_idle("R3");
        expect_reg(OFF_STAT, 32'h1, "R3", "write success code");
        start_write(12, 32'hDEAD_BEEF, 32'h0123_4567);
        wait_idle("R3");
        expect_reg(OFF_STAT, 32'h1, "R3", "second write success code");

        // R4 unkeyed erase is refused
        cmd(CMD_ERASE0);
        expect_reg(OFF_STAT, 32'h3, "R4", "unkeyed erase error");
        repeat (20) @(negedge clk);
        tally(mem[5] == 64'hAABB_CCDD_1122_3344, "R4", "bank untouched", mem[5], 64'hAABB_CCDD_1122_3344);

        // R5 keyed erase of bank 0 with clean verify
        keyed_erase(1'b0);
        wait_idle("R5");
        expect_reg(OFF_STAT, 32'h1, "R5", "erase verify pass");

        // R6 verify failure on bank 1 (word 10 never erases)
        stuck_en = 1'b1; stuck_idx = 10;
        keyed_erase(1'b1);
        wait_idle("R6");
        expect_reg(OFF_STAT, 32'hB, "R6", "verify failure status");
        stuck_en = 1'b0;

        // R8 commands while busy are ignored; R9 ignored command spends key
        start_write(3, 32'h5555_AAAA, 32'h0F0F_F0F0);
        bus_write(OFF_KEY, UNLOCK_KEY);
        cmd(CMD_ERASE1);
        cmd(CMD_ABORT);
        expect_reg(OFF_STAT, 32'h4, "R8", "still busy after ignored commands");
        wait_idle("R8");
        expect_reg(OFF_STAT, 32'h1, "R8", "running write completed");
        cmd(CMD_ERASE0);
        expect_reg(OFF_STAT, 32'h3, "R9", "key spent by ignored command");

        // R9 key spent by reserved command, and disarmed by wrong value
        bus_write(OFF_KEY, UNLOCK_KEY);
        cmd(5'b00111);
        cmd(CMD_ERASE0);
        expect_reg(OFF_STAT, 32'h3, "R9", "key spent by reserved command");
        bus_write(OFF_KEY, UNLOCK_KEY);
        bus_write(OFF_KEY, 32'h1234_5678);
        cmd(CMD_ERASE1);
        expect_reg(OFF_STAT, 32'h3, "R9", "key disarmed by wrong value");

        // R7 keyed abort during erase
        keyed_erase(1'b0);
        while (exp_q.size() > 0) void'(exp_q.pop_back());
        push(K_ERASE, 16'd0, '0);
        push(K_ABORT, 16'd0, '0);
        bus_write(OFF_KEY, UNLOCK_KEY);
        cmd(CMD_ABORT);
        expect_reg(OFF_STAT, 32'h3, "R7", "abort during erase");
        repeat (20) @(negedge clk);
        start_write(1, 32'hCAFE_0001, 32'hBEEF_0002);
        wait_idle("R7");
        expect_reg(OFF_STAT, 32'h1, "R7", "accepts command after abort");

        // R7 abort in the same cycle as array done
        start_write(7, 32'h7777_0000, 32'h0000_7777);
        bus_write(OFF_KEY, UNLOCK_KEY);
        push(K_ABORT, 16'd0, '0);
        do @(negedge clk); while (!fa_done);
        bus_wr = 1'b1; bus_addr = OFF_CMD; bus_wdata = {27'b0, CMD_ABORT};
        @(negedge clk);
        bus_wr = 1'b0;
        expect_reg(OFF_STAT, 32'h3, "R7", "abort wins over done");

        // R10 idle reserved code and idle abort
        start_write(2, 32'h2, 32'h0);
        wait_idle("R10");
        expect_reg(OFF_STAT, 32'h1, "R10", "write before reserved");
        cmd(5'b11111);
        expect_reg(OFF_STAT, 32'h3, "R10", "reserved code error");
        start_write(2, 32'h3, 32'h0);
        wait_idle("R10");
        cmd(CMD_ABORT);
        expect_reg(OFF_STAT, 32'h3, "R10", "unkeyed idle abort error");
        bus_write(OFF_KEY, UNLOCK_KEY);
        cmd(CMD_ABORT);
        expect_reg(OFF_STAT, 32'h3, "R10", "keyed idle abort error");

        repeat (10) @(negedge clk);
        tally(exp_q.size() == 0, "R5", "all expected strobes seen", 64'(exp_q.size()), 64'h0);

        if (!closed) begin
            closed = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule